// File: doc/BRIEF.md
# Command Ring Packet Processor

This block walks a circular command ring held in memory, one 32-bit word at a time, and carries out the type-3 packets it finds there. Software fills the ring and advances a 64-bit write pointer. It then pulses a start strobe. The engine fetches words at its own 64-bit read pointer and keeps executing packets until the two pointers are equal. The ring slot for any pointer value is the pointer modulo the ring depth in words. The pointers themselves only ever count upward.

Six packet kinds are understood. A register burst streams values into consecutive registers through a write port. A conditional wait compares a value against an immediate or against a word read from memory. A release writes either a supplied 64-bit value or a free-running 64-bit timestamp back to memory. A dispatch raises a one-cycle strobe carrying three grid sizes. An event packet is consumed with no effect, and so is a cache-acquire packet. When a wait is not satisfied, the engine moves its read pointer back to that packet's header and parks. It tries again when it receives a new start pulse or when a poll interval runs out. A malformed packet sets a sticky error and freezes the engine until reset.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the read pointer is 0, `busy` and `err` are low, and no memory request, register write or dispatch strobe is active.
- R2: A header whose bits 31:30 are not 2'b11 sets `err`, and it stays set until reset.
- R3: Each ring word is read at byte address `ring_base + 4*(rd_ptr mod RING_DW)`, and the read pointer advances by exactly one for every ring word accepted, so packets wrap across the end of the ring.
- R4: A `kick` pulse starts processing. Packets are executed while `rd_ptr < wr_ptr`, and the engine returns to idle (`busy` low) when the two are equal.
- R5: A register-burst packet (opcode 0x76 in header bits 15:8, count N in bits 29:16) carries a start register index followed by N values, which are written to index, index+1, … index+N-1.
- R6: A wait packet (opcode 0x3C, count 5) carries an info word with the compare function in bits 2:0 (5 = greater-or-equal, 3 = equal) and a space select in bit 4. Select 0 compares the reference word (fourth body word) against itself, so the wait passes at once.
- R7: With space select 1, the wait reads the 32-bit word at the 64-bit address {body word 3, body word 2} and compares it with the reference using the chosen function.
- R8: A failed wait rewinds the read pointer by 7 to the packet's header and halts without executing later packets. The wait is re-evaluated only on a new `kick` or after POLL_CYC stalled cycles.
- R9: A release packet (opcode 0x49, count 6) whose data select (second body word, bits 31:29) is 1 or 2 writes the 64-bit value {body word 6, body word 5} to the address {body word 4, body word 3}.
- R10: A release with data select 3 and event type 0x14 (first body word, bits 7:0) writes the current 64-bit free-running cycle timestamp, which increases between writes.
- R11: A dispatch packet (opcode 0x15, count 3) raises `disp_pulse` for exactly one cycle with `disp_x/y/z` set to the first three body words. The fourth word is ignored.
- R12: An event packet (opcode 0x46, count 0, one body word) and an acquire packet (opcode 0x58, count 6, seven body words) advance the read pointer and cause no memory write, register write or dispatch.
- R13: An unknown opcode, a count that does not match the opcode, a wait function other than 3 or 5, or an unsupported release select sets the sticky `err`. Once `err` is set, no further fetch, write or dispatch happens, even after a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick | input | 1 | Start / retry pulse |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| wr_ptr | input | PTR_W | Software write pointer, in words |
| rd_ptr | output | PTR_W | Engine read pointer, in words |
| busy | output | 1 | Engine active or parked on a wait |
| err | output | 1 | Sticky malformed-packet flag |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = 64-bit write, 0 = 32-bit read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | REG_AW | Register index |
| reg_wdata | output | 32 | Register write data |
| disp_pulse | output | 1 | One-cycle dispatch strobe |
| disp_x | output | 32 | Grid size X |
| disp_y | output | 32 | Grid size Y |
| disp_z | output | 32 | Grid size Z |

## Verification
The hardest case to reach is a parked wait and the two ways it can resume. The bench places a memory-compare wait, followed by a dispatch, in the ring while the polled word holds a failing value. It then checks that the pointer sits on the wait's header and that no strobe has appeared. Next it changes the polled word and waits for less than the poll interval, to show that nothing moves without a trigger. Finally it resumes the engine once by kick and, in a second case, only by letting the interval expire. Memory grants are withheld on a fixed rhythm, so every fetch and write-back also has to survive back-pressure.

// File: rtl/crp_pkg.sv
package crp_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_CHECK, S_HDR, S_BODY, S_REGV, S_EXEC, S_MRD, S_MWR, S_STALL, S_ERR
   } crp_state_e;

   localparam logic [7:0] OP_REGBURST = 8'h76;
   localparam logic [7:0] OP_WAIT     = 8'h3C;
   localparam logic [7:0] OP_RELEASE  = 8'h49;
   localparam logic [7:0] OP_DISPATCH = 8'h15;
   localparam logic [7:0] OP_EVENT    = 8'h46;
   localparam logic [7:0] OP_ACQUIRE  = 8'h58;

   localparam logic [2:0] FN_EQ       = 3'd3;
   localparam logic [2:0] FN_GE       = 3'd5;
   localparam logic [7:0] EV_STAMP    = 8'h14;
   localparam int         REWIND_DW   = 7;

endpackage

// File: rtl/crp_ring_addr.sv
module crp_ring_addr #(
   parameter int ADDR_W  = 64,
   parameter int RING_DW = 256
) (
   input  logic [ADDR_W-1:0]           base,
   input  logic [$clog2(RING_DW)-1:0]  slot,
   output logic [ADDR_W-1:0]           addr
);
   localparam int LG = $clog2(RING_DW);

   generate
      if (RING_DW < 2 || (1 << LG) != RING_DW) begin : g_bad_depth
         $error("RING_DW must be a power of two of at least 2");
      end
   endgenerate

   logic [LG+1:0] byte_off;
   assign byte_off = {slot, 2'b00};
   assign addr     = base + ADDR_W'(byte_off);
endmodule

// File: rtl/crp_hdr_decode.sv
module crp_hdr_decode import crp_pkg::*; (
   input  logic [31:8] word,
   output logic        type_ok,
   output logic        op_known,
   output logic        cnt_ok
);
   logic [7:0]  op;
   logic [13:0] cnt;

   assign op      = word[15:8];
   assign cnt     = word[29:16];
   assign type_ok = (word[31:30] == 2'b11);

   always_comb begin
      op_known = 1'b1;
      cnt_ok   = 1'b0;
      unique case (op)
         OP_REGBURST: cnt_ok = 1'b1;
         OP_WAIT:     cnt_ok = (cnt == 14'd5);
         OP_RELEASE:  cnt_ok = (cnt == 14'd6);
         OP_DISPATCH: cnt_ok = (cnt == 14'd3);
         OP_EVENT:    cnt_ok = (cnt == 14'd0);
         OP_ACQUIRE:  cnt_ok = (cnt == 14'd6);
         default:     op_known = 1'b0;
      endcase
   end
endmodule

// File: rtl/crp_wait_eval.sv
module crp_wait_eval import crp_pkg::*; (
   input  logic [2:0]  func,
   input  logic [31:0] lhs,
   input  logic [31:0] rhs,
   output logic        fn_ok,
   output logic        pass
);
   always_comb begin
      fn_ok = 1'b1;
      pass  = 1'b0;
      if (func == FN_GE)      pass = (lhs >= rhs);
      else if (func == FN_EQ) pass = (lhs == rhs);
      else                    fn_ok = 1'b0;
   end
endmodule

// File: rtl/crp_stamp.sv
module crp_stamp #(
   parameter int W = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [63:0] value
);
   generate
      if (W < 1 || W > 64) begin : g_bad_width
         $error("stamp width must be 1..64");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   generate
      if (W == 64) begin : g_full
         assign value = cnt;
      end else begin : g_pad
         assign value = {{(64-W){1'b0}}, cnt};
      end
   endgenerate
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine import crp_pkg::*; #(
   parameter int ADDR_W   = 64,
   parameter int PTR_W    = 64,
   parameter int RING_DW  = 256,
   parameter int REG_AW   = 16,
   parameter int POLL_CYC = 64,
   parameter int STAMP_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              busy,
   output logic              err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              reg_we,
   output logic [REG_AW-1:0] reg_addr,
   output logic [31:0]       reg_wdata,
   output logic              disp_pulse,
   output logic [31:0]       disp_x,
   output logic [31:0]       disp_y,
   output logic [31:0]       disp_z
);
   localparam int BODY_MAX = 7;
   localparam int IDX_W    = $clog2(BODY_MAX);
   localparam int RING_LG  = $clog2(RING_DW);
   localparam int PCNT_W   = $clog2(POLL_CYC + 1);

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must be 8..64");
      end
      if (PTR_W < RING_LG + 1 || PTR_W > 64) begin : g_bad_ptr
         $error("PTR_W too small for the ring or above 64");
      end
      if (REG_AW < 1 || REG_AW > 32) begin : g_bad_reg
         $error("REG_AW must be 1..32");
      end
      if (POLL_CYC < 1) begin : g_bad_poll
         $error("POLL_CYC must be at least 1");
      end
   endgenerate

   crp_state_e           state;
   logic [7:0]           op_q;
   logic [13:0]          cnt_q;
   logic [IDX_W-1:0]     idx;
   logic [31:0]          body_q [BODY_MAX];
   logic [13:0]          rem;
   logic [REG_AW-1:0]    cur_reg;
   logic [PCNT_W-1:0]    pcnt;
   logic [63:0]          wdata_q;
   logic [ADDR_W-1:0]    waddr_q;
   logic                 err_q;

   logic [ADDR_W-1:0]    fetch_addr;
   logic                 type_ok, op_known, cnt_ok;
   logic                 fn_ok, cmp_pass;
   logic [31:0]          cmp_lhs;
   logic [63:0]          stamp;
   logic [63:0]          wait_a64, rel_a64;
   logic [2:0]           rel_sel;

   crp_ring_addr #(.ADDR_W(ADDR_W), .RING_DW(RING_DW)) u_addr (
      .base (ring_base),
      .slot (rd_ptr[RING_LG-1:0]),
      .addr (fetch_addr)
   );

   crp_hdr_decode u_dec (
      .word     (mem_rdata[31:8]),
      .type_ok  (type_ok),
      .op_known (op_known),
      .cnt_ok   (cnt_ok)
   );

   assign cmp_lhs = (state == S_MRD) ? mem_rdata : body_q[3];

   crp_wait_eval u_cmp (
      .func  (body_q[0][2:0]),
      .lhs   (cmp_lhs),
      .rhs   (body_q[3]),
      .fn_ok (fn_ok),
      .pass  (cmp_pass)
   );

   crp_stamp #(.W(STAMP_W)) u_ts (
      .clk   (clk),
      .rst_n (rst_n),
      .value (stamp)
   );

   assign wait_a64 = {body_q[2], body_q[1]};
   assign rel_a64  = {body_q[3], body_q[2]};
   assign rel_sel  = body_q[1][31:29];

   // memory request steering
   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = fetch_addr;
      unique case (state)
         S_HDR, S_BODY, S_REGV: mem_req = 1'b1;
         S_MRD: begin
            mem_req  = 1'b1;
            mem_addr = wait_a64[ADDR_W-1:0];
         end
         S_MWR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = waddr_q;
         end
         default: ;
      endcase
   end

   assign mem_wdata = wdata_q;
   assign busy      = (state != S_IDLE) && (state != S_ERR);
   assign err       = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         rd_ptr     <= '0;
         op_q       <= '0;
         cnt_q      <= '0;
         idx        <= '0;
         rem        <= '0;
         cur_reg    <= '0;
         pcnt       <= '0;
         wdata_q    <= '0;
         waddr_q    <= '0;
         err_q      <= 1'b0;
         reg_we     <= 1'b0;
         reg_addr   <= '0;
         reg_wdata  <= '0;
         disp_pulse <= 1'b0;
         disp_x     <= '0;
         disp_y     <= '0;
         disp_z     <= '0;
         for (int i = 0; i < BODY_MAX; i++) body_q[i] <= '0;
      end else begin
         reg_we     <= 1'b0;
         disp_pulse <= 1'b0;
         unique case (state)
            S_IDLE: if (kick) state <= S_CHECK;

            S_CHECK: state <= (rd_ptr < wr_ptr) ? S_HDR : S_IDLE;

            S_HDR: if (mem_ack) begin
               rd_ptr <= rd_ptr + 1'b1;
               op_q   <= mem_rdata[15:8];
               cnt_q  <= mem_rdata[29:16];
               idx    <= '0;
               if (!type_ok || !op_known || !cnt_ok) begin
                  err_q <= 1'b1;
                  state <= S_ERR;
               end else begin
                  state <= S_BODY;
               end
            end

            S_BODY: if (mem_ack) begin
               rd_ptr      <= rd_ptr + 1'b1;
               body_q[idx] <= mem_rdata;
               idx         <= idx + 1'b1;
               if (op_q == OP_REGBURST) begin
                  cur_reg <= mem_rdata[REG_AW-1:0];
                  rem     <= cnt_q;
                  state   <= (cnt_q == '0) ? S_CHECK : S_REGV;
               end else if (14'(idx) == cnt_q) begin
                  state <= S_EXEC;
               end
            end

            S_REGV: if (mem_ack) begin
               rd_ptr    <= rd_ptr + 1'b1;
               reg_we    <= 1'b1;
               reg_addr  <= cur_reg;
               reg_wdata <= mem_rdata;
               cur_reg   <= cur_reg + 1'b1;
               rem       <= rem - 1'b1;
               if (rem == 14'd1) state <= S_CHECK;
            end

            S_EXEC: begin
               unique case (op_q)
                  OP_WAIT: begin
                     if (!fn_ok) begin
                        err_q <= 1'b1;
                        state <= S_ERR;
                     end else if (body_q[0][4]) begin
                        state <= S_MRD;
                     end else if (cmp_pass) begin
                        state <= S_CHECK;
                     end else begin
                        rd_ptr <= rd_ptr - PTR_W'(REWIND_DW);
                        pcnt   <= '0;
                        state  <= S_STALL;
                     end
                  end
                  OP_RELEASE: begin
                     waddr_q <= rel_a64[ADDR_W-1:0];
                     if (rel_sel == 3'd1 || rel_sel == 3'd2) begin
                        wdata_q <= {body_q[5], body_q[4]};
                        state   <= S_MWR;
                     end else if (rel_sel == 3'd3 && body_q[0][7:0] == EV_STAMP) begin
                        wdata_q <= stamp;
                        state   <= S_MWR;
                     end else begin
                        err_q <= 1'b1;
                        state <= S_ERR;
                     end
                  end
                  OP_DISPATCH: begin
                     disp_pulse <= 1'b1;
                     disp_x     <= body_q[0];
                     disp_y     <= body_q[1];
                     disp_z     <= body_q[2];
                     state      <= S_CHECK;
                  end
                  default: state <= S_CHECK;
               endcase
            end

            S_MRD: if (mem_ack) begin
               if (cmp_pass) begin
                  state <= S_CHECK;
               end else begin
                  rd_ptr <= rd_ptr - PTR_W'(REWIND_DW);
                  pcnt   <= '0;
                  state  <= S_STALL;
               end
            end

            S_MWR: if (mem_ack) state <= S_CHECK;

            S_STALL: begin
               if (kick || pcnt == PCNT_W'(POLL_CYC - 1)) begin
                  pcnt  <= '0;
                  state <= S_CHECK;
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end

            S_ERR: state <= S_ERR;

            default: state <= S_IDLE;
         endcase
      end
   end

   logic stalled;
   assign stalled = (state == S_STALL);

   AST_BAD_TYPE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HDR && mem_ack && mem_rdata[31:30] != 2'b11) |=> err); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + 1'b1)
      || (rd_ptr == $past(rd_ptr) - PTR_W'(REWIND_DW))); // R3
   AST_REG_CONSEC: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && $past(reg_we)) |-> (reg_addr == $past(reg_addr) + 1'b1)); // R5
   AST_STALL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && !$past(stalled)) |-> (rd_ptr == $past(rd_ptr) - PTR_W'(REWIND_DW))); // R8
   AST_DISP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      disp_pulse |=> !disp_pulse); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R13
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_req && !reg_we && !disp_pulse)); // R13

endmodule

// File: tb/cmd_ring_engine_test.sv
module cmd_ring_engine_test;
   localparam int RDW  = 64;
   localparam int POLL = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0;
   logic [63:0] ring_base = 64'h400;
   logic [63:0] wr_ptr = '0;
   logic [63:0] rd_ptr;
   logic        busy, err;
   logic        mem_req, mem_we, mem_ack;
   logic [63:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata;
   logic        reg_we;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata;
   logic        disp_pulse;
   logic [31:0] disp_x, disp_y, disp_z;

   always #5 clk = ~clk;

   cmd_ring_engine #(.RING_DW(RDW), .POLL_CYC(POLL)) uut (
      .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(ring_base), .wr_ptr(wr_ptr),
      .rd_ptr(rd_ptr), .busy(busy), .err(err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .disp_pulse(disp_pulse), .disp_x(disp_x), .disp_y(disp_y), .disp_z(disp_z));

   // memory model: 1024 words, grants withheld every third cycle
   logic [31:0] mem [0:1023];
   int          cyc = 0;
   logic        rdy = 1'b1;
   int          mwr_cnt = 0, reg_cnt = 0, disp_cnt = 0, addr_bad = 0;
   logic [31:0] regs [0:255];
   logic [31:0] dx = 0, dy = 0, dz = 0;

   assign mem_ack   = mem_req & rdy;
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      rdy <= ((cyc % 3) != 1);
      if (mem_req && mem_ack && !mem_we && mem_addr < 64'h800)
         if (mem_addr != 64'h400 + {56'd0, rd_ptr[5:0], 2'b00}) addr_bad <= addr_bad + 1;
   end

   always @(posedge clk) begin
      if (mem_req && mem_we && mem_ack) begin
         mem[mem_addr[11:2]]        <= mem_wdata[31:0];
         mem[mem_addr[11:2] + 10'd1] <= mem_wdata[63:32];
         mwr_cnt <= mwr_cnt + 1;
      end
      if (reg_we) begin
         regs[reg_addr[7:0]] <= reg_wdata;
         reg_cnt <= reg_cnt + 1;
      end
      if (disp_pulse) begin
         disp_cnt <= disp_cnt + 1;
         dx <= disp_x; dy <= disp_y; dz <= disp_z;
      end
   end

   int          nchk = 0, nfail = 0;
   logic [63:0] wr = '0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input logic [7:0] op, input logic [13:0] cnt);
      return {2'b11, cnt, op, 8'h00};
   endfunction

   task automatic put(input logic [31:0] d);
      mem[10'h100 + {4'd0, wr[5:0]}] <= d;
      wr = wr + 1;
   endtask

   task automatic pulse_kick();
      @(negedge clk);
      wr_ptr = wr;
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
   endtask

   task automatic run();
      pulse_kick();
      wait_idle();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr = '0;
      wr_ptr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(rd_ptr == 0, "R1 rd_ptr", rd_ptr, 0);
      chk(!busy && !err, "R1 busy/err", {busy, err}, 0);
      chk(!mem_req && !reg_we && !disp_pulse, "R1 quiet", {mem_req, reg_we, disp_pulse}, 0);
   endtask

   task automatic t_burst();
      int r0 = reg_cnt;
      put(hdr(8'h76, 14'd3)); put(32'h10);
      put(32'hA1); put(32'hB2); put(32'hC3);
      run();
      chk(regs[8'h10] == 32'hA1, "R5 reg10", regs[8'h10], 32'hA1);
      chk(regs[8'h11] == 32'hB2, "R5 reg11", regs[8'h11], 32'hB2);
      chk(regs[8'h12] == 32'hC3, "R5 reg12", regs[8'h12], 32'hC3);
      chk(reg_cnt - r0 == 3, "R5 write count", reg_cnt - r0, 3);
      chk(rd_ptr == wr && !busy, "R4 stop at wr_ptr", rd_ptr, wr);
   endtask

   task automatic t_dispatch();
      int d0 = disp_cnt;
      put(hdr(8'h15, 14'd3)); put(32'd7); put(32'd8); put(32'd9); put(32'hFFFF);
      run();
      chk(disp_cnt - d0 == 1, "R11 one pulse", disp_cnt - d0, 1);
      chk({dx, dy, dz} == {32'd7, 32'd8, 32'd9}, "R11 grid", {dx, dy[15:0], dz[15:0]}, {32'd7, 16'd8, 16'd9});
   endtask

   task automatic t_skip();
      int m0 = mwr_cnt, r0 = reg_cnt, d0 = disp_cnt;
      logic [63:0] p0 = wr;
      put(hdr(8'h46, 14'd0)); put(32'h1234);
      put(hdr(8'h58, 14'd6));
      for (int i = 0; i < 7; i++) put(32'h55 + i);
      run();
      chk(rd_ptr == p0 + 10, "R12 consumed", rd_ptr, p0 + 10);
      chk(mwr_cnt == m0 && reg_cnt == r0 && disp_cnt == d0, "R12 no effect",
          mwr_cnt - m0 + reg_cnt - r0 + disp_cnt - d0, 0);
   endtask

   task automatic release_pkt(input logic [7:0] ev, input logic [2:0] sel,
                              input logic [31:0] a, input logic [63:0] v);
      put(hdr(8'h49, 14'd6)); put({24'd0, ev}); put({sel, 29'd0});
      put(a); put(32'd0); put(v[31:0]); put(v[63:32]); put(32'd0);
   endtask

   task automatic t_release();
      release_pkt(8'h0, 3'd1, 32'h800, 64'h01234567_DEADBEEF);
      release_pkt(8'h0, 3'd2, 32'h810, 64'hCAFE0000_0000F00D);
      run();
      chk({mem[10'h201], mem[10'h200]} == 64'h01234567_DEADBEEF, "R9 sel1",
          {mem[10'h201], mem[10'h200]}, 64'h01234567_DEADBEEF);
      chk({mem[10'h205], mem[10'h204]} == 64'hCAFE0000_0000F00D, "R9 sel2",
          {mem[10'h205], mem[10'h204]}, 64'hCAFE0000_0000F00D);
   endtask

   task automatic t_stamp();
      logic [63:0] s0, s1;
      release_pkt(8'h14, 3'd3, 32'h820, 64'h0);
      release_pkt(8'h14, 3'd3, 32'h828, 64'h0);
      run();
      s0 = {mem[10'h209], mem[10'h208]};
      s1 = {mem[10'h20B], mem[10'h20A]};
      chk(s0 != 0, "R10 stamp written", s0, 1);
      chk(s1 > s0, "R10 stamp increases", s1, s0 + 1);
   endtask

   task automatic wait_pkt(input logic [2:0] fn, input bit space, input logic [31:0] a,
                           input logic [31:0] v);
      put(hdr(8'h3C, 14'd5)); put({27'd0, space, 1'b0, fn}); put(a); put(32'd0);
      put(v); put(32'hFFFFFFFF); put(32'd0);
   endtask

   task automatic t_wait_pass();
      int d0 = disp_cnt;
      mem[10'h240] <= 32'd9;
      wait_pkt(3'd3, 1'b0, 32'h0, 32'h77);
      wait_pkt(3'd5, 1'b0, 32'h0, 32'h77);
      wait_pkt(3'd5, 1'b1, 32'h900, 32'd5);
      put(hdr(8'h15, 14'd3)); put(32'd1); put(32'd2); put(32'd3); put(32'd0);
      run();
      chk(disp_cnt - d0 == 1, "R6 immediate waits pass", disp_cnt - d0, 1);
      chk(rd_ptr == wr, "R7 ge on memory passes", rd_ptr, wr);
      chk(rd_ptr > RDW, "R3 ring wrapped", rd_ptr, RDW + 1);
      chk(addr_bad == 0, "R3 fetch address", addr_bad, 0);
   endtask

   task automatic t_wait_kick();
      int d0 = disp_cnt;
      logic [63:0] h;
      mem[10'h240] <= 32'd1;
      h = wr;
      wait_pkt(3'd5, 1'b1, 32'h900, 32'd5);
      put(hdr(8'h15, 14'd3)); put(32'd4); put(32'd5); put(32'd6); put(32'd0);
      pulse_kick();
      repeat (40) @(negedge clk);
      chk(rd_ptr == h, "R8 rewound to header", rd_ptr, h);
      chk(disp_cnt == d0 && busy, "R8 halted", disp_cnt - d0, 0);
      mem[10'h240] <= 32'd5;
      repeat (30) @(negedge clk);
      chk(rd_ptr == h, "R8 no retry before trigger", rd_ptr, h);
      run();
      chk(disp_cnt - d0 == 1, "R8 kick retry", disp_cnt - d0, 1);
      chk(rd_ptr == wr, "R7 memory wait done", rd_ptr, wr);
   endtask

   task automatic t_wait_poll();
      int d0 = disp_cnt;
      mem[10'h240] <= 32'h10;
      wait_pkt(3'd3, 1'b1, 32'h900, 32'h20);
      put(hdr(8'h15, 14'd3)); put(32'd1); put(32'd1); put(32'd1); put(32'd0);
      pulse_kick();
      repeat (20) @(negedge clk);
      chk(disp_cnt == d0, "R7 eq mismatch holds", disp_cnt - d0, 0);
      mem[10'h240] <= 32'h20;
      wait_idle();
      chk(disp_cnt - d0 == 1 && rd_ptr == wr, "R8 poll retry", disp_cnt - d0, 1);
   endtask

   task automatic t_err(input string tag, input int exp_ptr);
      int d0 = disp_cnt;
      logic [63:0] p;
      run();
      chk(err && !busy, tag, {busy, err}, 1);
      chk(rd_ptr == exp_ptr, {tag, " stop point"}, rd_ptr, exp_ptr);
      p = rd_ptr;
      put(hdr(8'h15, 14'd3)); put(32'd1); put(32'd1); put(32'd1); put(32'd0);
      run();
      chk(rd_ptr == p && disp_cnt == d0 && err, "R13 sticky", rd_ptr, p);
   endtask

   task automatic t_errors();
      do_reset();
      put(32'h8000_1500);
      t_err("R2 bad type", 1);
      do_reset();
      put(hdr(8'h99, 14'd0));
      t_err("R13 unknown op", 1);
      do_reset();
      put(hdr(8'h15, 14'd2)); put(32'd1); put(32'd1); put(32'd1);
      t_err("R13 count mismatch", 1);
      do_reset();
      wait_pkt(3'd0, 1'b0, 32'h0, 32'h0);
      t_err("R13 bad function", 7);
      do_reset();
      release_pkt(8'h0, 3'd0, 32'h830, 64'h1);
      t_err("R13 bad select", 8);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      for (int i = 0; i < 256; i++) regs[i] = '0;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_burst();
      t_dispatch();
      t_skip();
      t_release();
      t_stamp();
      t_wait_pass();
      t_wait_kick();
      t_wait_poll();
      t_errors();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule